// File: doc/BRIEF.md
# Prefetch Buffer Host Read Port

This block is the host-facing read side of a small prefetch store that holds 32-bit Dwords fetched ahead of a processor read. A 3-bit command, qualified by a strobe, selects what the block places on a 64-bit host data bus. Each half of the bus has its own output enable. The commands are: leave the bus undriven, restart at the first entry, step through entries with two alternating step codes, present two fixed entries side by side, or pass memory data through a transparent latch. The step rule keeps a burst from being advanced twice. The pointer moves only when a step code differs from the one before it. A repeated step code drives the same Dword again.

The command in force is held in a register. It stays in force until the next strobe, and it also serves as the previous command when the step rule is applied. A synchronous load port fills the entries from the fetch side. The bus outputs are combinational from the held command, the pointer, the stored entries and the memory path. A new command therefore shows on the bus in the cycle after the strobe edge.

Top module: `pf_host_read_port`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 0, both output enables are low and the bus value is zero.
- R2: Code 0 (idle), and the unused codes 6 and 7, drive nothing: both enables are low and the bus value reads zero.
- R3: Code 1 (restart) sets the pointer to 0 and drives entry 0 on both bus halves, with both enables high.
- R4: Code 2 (step A), when the previous command was code 1 or code 3, advances the pointer by one and drives the new entry on both halves.
- R5: Code 2 after any other previous command (including another code 2, idle or reset) leaves the pointer unchanged and drives the current entry on both halves.
- R6: Code 3 (step B), when the previous command was code 2, advances the pointer by one and drives the new entry on both halves.
- R7: Code 3 after any other previous command (including another code 3, idle or reset) leaves the pointer unchanged and drives the current entry on both halves.
- R8: The pointer counts modulo 8 and wraps from 7 to 0.
- R9: Code 4 (pair read) drives entry 0 on bits 31:0 and entry 1 on bits 63:32, whatever the pointer holds, and leaves the pointer unchanged.
- R10: Code 5 (memory read), while the latch enable is high, passes the 64-bit memory input straight to the bus in the same cycle, with both enables high.
- R11: Code 5, while the latch enable is low, drives the memory value sampled at the last clock edge at which the enable was high.
- R12: With the strobe low, the command input has no effect: the pointer, the held command and the bus stay as they were.
- R13: A load with write enable high writes the 32-bit data to the entry at the 3-bit index on the clock edge, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | Command strobe |
| cmd | input | 3 | Command code |
| ld_en | input | 1 | Entry load enable |
| ld_idx | input | 3 | Entry index to load |
| ld_data | input | 32 | Dword to load |
| mem_le | input | 1 | Memory latch enable, high means transparent |
| mem_data | input | 64 | Memory data for the read-through path |
| host_dout | output | 64 | Host data bus value |
| host_oe_lo | output | 1 | Enable for bits 31:0 |
| host_oe_hi | output | 1 | Enable for bits 63:32 |
| rd_ptr | output | 3 | Current read pointer |

## Verification
The assertions assume that the command input matters only in cycles where the strobe is high. They also assume that the memory latch enable is a plain level that may change in any cycle. They make no assumption about the order of commands, because the step rule has to hold for every pair of codes. The stimulus sweeps every ordered pair of the eight codes, starting from a pointer value other than zero, so that both the advance and the repeat cases are reached. It also runs a long alternating chain to force the pointer to wrap. In the memory tests the latch enable is held high across a clock edge before it is dropped, so the captured value is well defined.

// File: rtl/pfrd_pkg.sv
// Shared command codes for the prefetch host read port.
package pfrd_pkg;
    typedef enum logic [2:0] {
        PF_IDLE  = 3'd0,
        PF_FIRST = 3'd1,
        PF_NEXTA = 3'd2,
        PF_NEXTB = 3'd3,
        PF_QUAD  = 3'd4,
        PF_MEMRD = 3'd5,
        PF_RSV6  = 3'd6,
        PF_RSV7  = 3'd7
    } pf_cmd_e;
endpackage

// File: rtl/pf_entry_store.sv
// Prefetch entry storage.
// Holds DEPTH Dwords written through a synchronous load port and offers one
// pointer-indexed read plus fixed reads of entries 0 and 1.
// Assumes DEPTH >= 2 and that the load index is below DEPTH.
module pf_entry_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [PW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic [PW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ent0,
    output logic [DW-1:0] ent1
);
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        // Load one entry when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[gi] <= '0;
            else if (ld_en && (ld_idx == PW'(gi)))
                mem_q[gi] <= ld_data;
        end

        // R13
        load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_en && ld_idx == PW'(gi)) |=> (mem_q[gi] == $past(ld_data)));
    end

    // Select the pointed-to entry and expose the two fixed entries.
    always_comb begin
        rd_data = mem_q[rd_idx];
        ent0    = mem_q[0];
        ent1    = mem_q[1];
    end
endmodule

// File: rtl/pf_ptr_ctrl.sv
// Command register and read pointer.
// Latches each strobed command. The latched command stays in force for the
// bus and also acts as the previous command for the step rule. The pointer
// advances only when a step code follows its partner code.
// Assumes the command input is meaningful only while cmd_vld is high.
module pf_ptr_ctrl
    import pfrd_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_vld,
    input  logic [2:0]    cmd,
    output pf_cmd_e       cur_cmd,
    output logic [PW-1:0] rd_ptr
);
    pf_cmd_e       new_cmd;
    logic [PW-1:0] ptr_nxt;

    // Decide the next pointer from the new command and the held command.
    always_comb begin
        new_cmd = pf_cmd_e'(cmd);
        ptr_nxt = rd_ptr;
        case (new_cmd)
            PF_FIRST: ptr_nxt = '0;
            PF_NEXTA: if (cur_cmd == PF_FIRST || cur_cmd == PF_NEXTB)
                          ptr_nxt = rd_ptr + 1'b1;
            PF_NEXTB: if (cur_cmd == PF_NEXTA)
                          ptr_nxt = rd_ptr + 1'b1;
            default:  ptr_nxt = rd_ptr;
        endcase
    end

    // Register the command and the pointer on a strobed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cmd <= PF_IDLE;
            rd_ptr  <= '0;
        end else if (cmd_vld) begin
            cur_cmd <= new_cmd;
            rd_ptr  <= ptr_nxt;
        end
    end

    // R3
    first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == 3'd1) |=> (rd_ptr == '0));

    // R4
    stepa_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == 3'd2 && (cur_cmd == PF_FIRST || cur_cmd == PF_NEXTB))
        |=> (rd_ptr == PW'($past(rd_ptr) + 1'b1)));

    // R5
    stepa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == 3'd2 && cur_cmd != PF_FIRST && cur_cmd != PF_NEXTB)
        |=> $stable(rd_ptr));

    // R6
    stepb_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == 3'd3 && cur_cmd == PF_NEXTA)
        |=> (rd_ptr == PW'($past(rd_ptr) + 1'b1)));

    // R7
    stepb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == 3'd3 && cur_cmd != PF_NEXTA) |=> $stable(rd_ptr));

    // R12
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> ($stable(rd_ptr) && $stable(cur_cmd)));
endmodule

// File: rtl/pf_mem_latch.sv
// Memory read-through latch, modelled synchronously.
// While mem_le is high the input passes through. The value present at each
// clock edge with mem_le high is captured, and it is shown while mem_le is low.
// Assumes mem_le is a level held across clock edges.
module pf_mem_latch #(
    parameter int BW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_le,
    input  logic [BW-1:0] mem_data,
    output logic [BW-1:0] mem_view
);
    logic [BW-1:0] hold_q;

    // Capture memory data while the latch is open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (mem_le)
            hold_q <= mem_data;
    end

    // Pass through when open, otherwise show the captured value.
    always_comb mem_view = mem_le ? mem_data : hold_q;

    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_le |=> $stable(hold_q));
endmodule

// File: rtl/pf_bus_steer.sv
// Host bus steering.
// Chooses the 64-bit bus value and the two half enables from the held
// command. Undriven halves read zero.
// Assumes the entry and memory inputs are settled within the cycle.
module pf_bus_steer
    import pfrd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pf_cmd_e         cur_cmd,
    input  logic [DW-1:0]   sel_word,
    input  logic [DW-1:0]   ent0,
    input  logic [DW-1:0]   ent1,
    input  logic [2*DW-1:0] mem_view,
    output logic [2*DW-1:0] bus,
    output logic            oe_lo,
    output logic            oe_hi
);
    // Map the held command to a bus value and enables.
    always_comb begin
        bus   = '0;
        oe_lo = 1'b0;
        oe_hi = 1'b0;
        case (cur_cmd)
            PF_FIRST, PF_NEXTA, PF_NEXTB: begin
                bus   = {sel_word, sel_word};
                oe_lo = 1'b1;
                oe_hi = 1'b1;
            end
            PF_QUAD: begin
                bus   = {ent1, ent0};
                oe_lo = 1'b1;
                oe_hi = 1'b1;
            end
            PF_MEMRD: begin
                bus   = mem_view;
                oe_lo = 1'b1;
                oe_hi = 1'b1;
            end
            default: begin
                bus   = '0;
                oe_lo = 1'b0;
                oe_hi = 1'b0;
            end
        endcase
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_lo && !oe_hi) |-> (bus == '0));

    // R9
    pair_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cmd == PF_QUAD) |-> (bus[DW-1:0] == ent0 && bus[2*DW-1:DW] == ent1));
endmodule

// File: rtl/pf_host_read_port.sv
// Prefetch buffer host read port, top level.
// Joins the entry store, the pointer control, the memory latch and the bus
// steering. Bus outputs follow the held command in the cycle after a strobe.
// Assumes one clock domain and a synchronous active-low reset.
module pf_host_read_port
    import pfrd_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int CW    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_vld,
    input  logic [CW-1:0]            cmd,
    input  logic                     ld_en,
    input  logic [$clog2(DEPTH)-1:0] ld_idx,
    input  logic [DW-1:0]            ld_data,
    input  logic                     mem_le,
    input  logic [2*DW-1:0]          mem_data,
    output logic [2*DW-1:0]          host_dout,
    output logic                     host_oe_lo,
    output logic                     host_oe_hi,
    output logic [$clog2(DEPTH)-1:0] rd_ptr
);
    localparam int PW = $clog2(DEPTH);
    localparam int BW = 2 * DW;

    pf_cmd_e        cur_cmd;
    logic [DW-1:0]  sel_word;
    logic [DW-1:0]  ent0;
    logic [DW-1:0]  ent1;
    logic [BW-1:0]  mem_view;

    pf_entry_store #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_ptr), .rd_data(sel_word), .ent0(ent0), .ent1(ent1)
    );

    pf_ptr_ctrl #(.PW(PW)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .cmd_vld(cmd_vld), .cmd(cmd),
        .cur_cmd(cur_cmd), .rd_ptr(rd_ptr)
    );

    pf_mem_latch #(.BW(BW)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .mem_le(mem_le), .mem_data(mem_data), .mem_view(mem_view)
    );

    pf_bus_steer #(.DW(DW)) u_steer (
        .clk(clk), .rst_n(rst_n),
        .cur_cmd(cur_cmd), .sel_word(sel_word),
        .ent0(ent0), .ent1(ent1), .mem_view(mem_view),
        .bus(host_dout), .oe_lo(host_oe_lo), .oe_hi(host_oe_hi)
    );

    // R10
    mem_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cmd == PF_MEMRD && mem_le) |-> (host_dout == mem_data && host_oe_lo && host_oe_hi));

    // R8
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_ptr) == PW'(DEPTH-1) && rd_ptr != $past(rd_ptr) && cur_cmd != PF_FIRST)
        |-> (rd_ptr == '0));
endmodule

// File: tb/tb_pf_host_read_port.sv
`timescale 1ns/1ps
module tb_pf_host_read_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_vld = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = 3'd0;
    logic [31:0] ld_data = 32'd0;
    logic        mem_le = 1'b1;
    logic [63:0] mem_data = 64'hC0DE_0000_1234_5678;
    logic [63:0] host_dout;
    logic        host_oe_lo, host_oe_hi;
    logic [2:0]  rd_ptr;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mbuf [8];
    logic [2:0]  mptr = 3'd0;
    logic [2:0]  mprev = 3'd0;

    pf_host_read_port dut (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .mem_le(mem_le), .mem_data(mem_data),
        .host_dout(host_dout), .host_oe_lo(host_oe_lo), .host_oe_hi(host_oe_hi),
        .rd_ptr(rd_ptr)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [63:0] exp_d,
                         input logic exp_oe, input logic [2:0] exp_p);
        checks++;
        if (host_dout !== exp_d || host_oe_lo !== exp_oe ||
            host_oe_hi !== exp_oe || rd_ptr !== exp_p) begin
            fails++;
            $display("FAIL %s: dout=%h oe=%b%b ptr=%0d expected dout=%h oe=%b ptr=%0d",
                     req, host_dout, host_oe_hi, host_oe_lo, rd_ptr,
                     exp_d, exp_oe, exp_p);
        end
    endtask

    // Expected bus for the held command, from the requirements.
    task automatic expect_now(input string req);
        logic [63:0] d;
        logic        oe;
        case (mprev)
            3'd1, 3'd2, 3'd3: begin d = {mbuf[mptr], mbuf[mptr]}; oe = 1'b1; end
            3'd4:             begin d = {mbuf[1], mbuf[0]};       oe = 1'b1; end
            3'd5:             begin d = mem_data;                 oe = 1'b1; end
            default:          begin d = 64'd0;                    oe = 1'b0; end
        endcase
        check(req, d, oe, mptr);
    endtask

    task automatic issue(input logic [2:0] c);
        string req;
        @(negedge clk);
        cmd_vld = 1'b1;
        cmd = c;
        @(negedge clk);
        cmd_vld = 1'b0;
        case (c)
            3'd1: begin mptr = 3'd0; req = "R3"; end
            3'd2: if (mprev == 3'd1 || mprev == 3'd3) begin mptr = mptr + 3'd1; req = "R4"; end
                  else req = "R5";
            3'd3: if (mprev == 3'd2) begin mptr = mptr + 3'd1; req = "R6"; end
                  else req = "R7";
            3'd4: req = "R9";
            3'd5: req = "R10";
            default: req = "R2";
        endcase
        mprev = c;
        expect_now(req);
    endtask

    task automatic load(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        mbuf[idx] = d;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mbuf[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", 64'd0, 1'b0, 3'd0);

        // R13: fill entries with computed values
        for (int i = 0; i < 8; i++)
            load(3'(i), 32'h1000_0001 * (i + 1) ^ (32'hA5A5_0000 >> i));

        // R7: step B straight after reset holds
        issue(3'd3);
        // R5: step A after step B that did not advance still advances? prev=3 -> advance (R4)
        issue(3'd2);

        // Exhaustive ordered pairs of codes, each from pointer 2
        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 8; c++) begin
                issue(3'd1);
                issue(3'd2);
                issue(3'd3);
                issue(3'(p));
                issue(3'(c));
            end
        end

        // R8: long alternating chain wraps the pointer
        issue(3'd1);
        for (int k = 0; k < 20; k++) begin
            issue((k % 2 == 0) ? 3'd2 : 3'd3);
            checks++;
            if (rd_ptr !== 3'((k + 1) % 8)) begin
                fails++;
                $display("FAIL R8: ptr=%0d expected %0d", rd_ptr, (k + 1) % 8);
            end
        end

        // R12: strobe low ignores a restart command
        @(negedge clk);
        cmd = 3'd1;
        cmd_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        expect_now("R12");

        // R13: reload an entry under the pointer, then repeat-read it
        load(mptr, 32'hDEAD_BEEF);
        issue(mprev);
        expect_now("R13");

        // R10 / R11: memory read-through and hold
        mem_le = 1'b1;
        mem_data = 64'h1111_2222_3333_4444;
        issue(3'd5);
        @(negedge clk);
        mem_data = 64'h5555_6666_7777_8888;
        #1 check("R10", 64'h5555_6666_7777_8888, 1'b1, mptr);
        @(negedge clk);
        mem_le = 1'b0;
        mem_data = 64'h9999_AAAA_BBBB_CCCC;
        #1 check("R11", 64'h5555_6666_7777_8888, 1'b1, mptr);
        @(negedge clk);
        mem_data = 64'hDDDD_EEEE_FFFF_0000;
        #1 check("R11", 64'h5555_6666_7777_8888, 1'b1, mptr);
        mem_le = 1'b1;

        // R2: idle after memory read releases the bus
        issue(3'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule